// File: doc/BRIEF.md
# Operate-Class Conditional Skip Evaluator

This block decides how far the program counter of a 12-bit minicomputer moves for each instruction. It watches the instruction register, the accumulator and the link bit, together with two phase strobes from the sequencer. A fetch strobe always produces one increment enable. An execute strobe produces a second increment enable only when the instruction is a group-2 operate and its skip condition holds. A skip is therefore an extra counter step during execute. It is not a separate branch path.

The condition logic has two senses, chosen by one instruction bit. The OR sense takes the union of three tests: accumulator negative, accumulator zero and link set. The AND sense takes the intersection of their complements: accumulator positive, accumulator nonzero and link clear. In the AND sense, a test that is not selected counts as true. Both increment enables are registered and appear one clock after their strobe. A registered skip flag keeps the result of the last execute evaluation so that it can be observed.

Top module: `skip_eval`

## Requirements
- R1: After reset is released, and while reset is held, fetch_inc_o, exec_inc_o and skip_o are 0.
- R2: fetch_inc_o is 1 in the cycle after any cycle in which fetch_i is 1, and 0 otherwise, whatever the instruction and data inputs are.
- R3: The block treats an instruction as group-2 operate only when ir_i[11:9]=3'b111, ir_i[8]=1 and ir_i[0]=0. For any other ir_i, an execute strobe gives exec_inc_o=0 and skip_o=0 in the next cycle.
- R4: OR sense (ir_i[3]=0). Three bits select the tests: ir_i[6] selects accumulator-negative (ac_i[11]=1), ir_i[5] selects accumulator-zero and ir_i[4] selects link=1. The skip holds when at least one selected test is true. With nothing selected, there is no skip.
- R5: AND sense (ir_i[3]=1). The same three select bits choose accumulator-positive (ac_i[11]=0), accumulator-nonzero and link=0. The skip holds when every selected test is true. An unselected test counts as true.
- R6: Octal 7400 never skips and octal 7410 always skips, whatever the accumulator and link values.
- R7: Combined forms follow R4 and R5. Octal 7540 skips for accumulator 0000, 4000 and 7777 and not for 0001 or 3777. Octal 7550 skips for 0001 and 3777 and not for 0000, 4000 or 7777.
- R8: exec_inc_o is 1 in the cycle after an execute strobe whose instruction skips, and 0 in every other cycle.
- R9: skip_o takes the skip result in the cycle after each execute strobe. It keeps that value through cycles with no execute strobe, even if ir_i, ac_i or link_i change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 12 | Instruction register; ir_i[11] is the most significant bit |
| ac_i | input | 12 | Accumulator; ac_i[11] is the sign |
| link_i | input | 1 | Link bit |
| fetch_i | input | 1 | Fetch-phase strobe |
| exec_i | input | 1 | Execute-phase strobe |
| fetch_inc_o | output | 1 | PC increment enable for fetch, registered |
| exec_inc_o | output | 1 | PC increment enable for execute (skip), registered |
| skip_o | output | 1 | Result of the last execute evaluation |

## Verification
The accumulator values used are zero, one, the largest positive value, the most negative value and all ones. Together they separate the sign test from the zero test and the OR sense from the AND sense. Each link test runs with the link both set and clear. Two combined accumulator-and-link forms run with inputs that make the OR result differ from the AND result. Near-miss instructions check the group-2 decode: a group-1 operate, one with bit 0 set (ir_i[0]=1) and a memory-reference instruction. Changing the inputs with no execute strobe, and running fetch strobes alone, shows that the skip flag holds and that the two phase enables are independent.

// File: rtl/skip_pkg.sv
package skip_pkg;
  // decoded operate-group-2 fields
  typedef struct packed {
    logic is_grp2;
    logic sense_and;
    logic sel_sign;
    logic sel_zero;
    logic sel_link;
  } opr_fields_t;

  localparam int unsigned N_TESTS = 3;
endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_pkg::*;
#(
  parameter int unsigned IR_W = 12
) (
  input  logic [IR_W-1:0] ir_i,
  output opr_fields_t     fld_o
);
  // bit n counted from the MSB maps to vector index IR_W-1-n
  localparam int unsigned B_SENSE = IR_W - 1 - 8;
  localparam int unsigned B_SIGN  = IR_W - 1 - 5;
  localparam int unsigned B_ZERO  = IR_W - 1 - 6;
  localparam int unsigned B_LINK  = IR_W - 1 - 7;
  localparam int unsigned B_GRP   = IR_W - 1 - 3;
  localparam int unsigned B_LAST  = IR_W - 1 - 11;

  logic unused_bits;
  assign unused_bits = ^ir_i[IR_W-1-9 -: 2];

  always_comb begin
    fld_o.is_grp2   = (ir_i[IR_W-1 -: 3] == 3'b111) && ir_i[B_GRP] && !ir_i[B_LAST];
    fld_o.sense_and = ir_i[B_SENSE];
    fld_o.sel_sign  = ir_i[B_SIGN];
    fld_o.sel_zero  = ir_i[B_ZERO];
    fld_o.sel_link  = ir_i[B_LINK];
  end
endmodule

// File: rtl/skip_cond.sv
module skip_cond
  import skip_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  opr_fields_t       fld_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              link_i,
  output logic              skip_o
);
  logic [N_TESTS-1:0] sel;
  logic [N_TESTS-1:0] cond;   // {link set, ac zero, ac negative}
  logic [N_TESTS-1:0] and_term;
  logic               or_hit, and_hit;

  assign sel  = {fld_i.sel_link, fld_i.sel_zero, fld_i.sel_sign};
  assign cond = {link_i, ~|ac_i, ac_i[WORD_W-1]};

  // unselected tests are neutral in the AND sense
  for (genvar g = 0; g < N_TESTS; g++) begin : g_and
    assign and_term[g] = ~sel[g] | ~cond[g];
  end

  assign or_hit  = |(sel & cond);
  assign and_hit = &and_term;
  assign skip_o  = fld_i.is_grp2 && (fld_i.sense_and ? and_hit : or_hit);
endmodule

// File: rtl/skip_step.sv
module skip_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_i,
  input  logic exec_i,
  input  logic skip_i,
  output logic fetch_inc_o,
  output logic exec_inc_o,
  output logic skip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_inc_o <= 1'b0;
      exec_inc_o  <= 1'b0;
      skip_o      <= 1'b0;
    end else begin
      fetch_inc_o <= fetch_i;
      exec_inc_o  <= exec_i & skip_i;
      if (exec_i) skip_o <= skip_i;
    end
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ir_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              link_i,
  input  logic              fetch_i,
  input  logic              exec_i,
  output logic              fetch_inc_o,
  output logic              exec_inc_o,
  output logic              skip_o
);
  opr_fields_t fld;
  logic        skip_now;

  skip_decode #(.IR_W(WORD_W)) i_decode (
    .ir_i  (ir_i),
    .fld_o (fld)
  );

  skip_cond #(.WORD_W(WORD_W)) i_cond (
    .fld_i  (fld),
    .ac_i   (ac_i),
    .link_i (link_i),
    .skip_o (skip_now)
  );

  skip_step i_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch_i),
    .exec_i      (exec_i),
    .skip_i      (skip_now),
    .fetch_inc_o (fetch_inc_o),
    .exec_inc_o  (exec_inc_o),
    .skip_o      (skip_o)
  );
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int unsigned WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] ir_i,
  input logic [WORD_W-1:0] ac_i,
  input logic              link_i,
  input logic              fetch_i,
  input logic              exec_i,
  input logic              fetch_inc_o,
  input logic              exec_inc_o,
  input logic              skip_o
);
  logic grp2;
  assign grp2 = (ir_i[11:9] == 3'b111) && ir_i[8] && !ir_i[0];

  assert_fetch_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> fetch_inc_o);
  assert_fetch_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |=> !fetch_inc_o);
  assert_no_step_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !exec_inc_o);
  assert_step_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_inc_o |-> skip_o);
  assert_nongrp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !grp2) |=> (!exec_inc_o && !skip_o));
  assert_never_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && ir_i == 12'o7400) |=> !exec_inc_o);
  assert_always_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && ir_i == 12'o7410) |=> exec_inc_o);
  assert_or_minus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp2 && !ir_i[3] && ir_i[6] && ac_i[11]) |=> exec_inc_o);
  assert_and_minus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp2 && ir_i[3] && ir_i[6] && ac_i[11]) |=> !exec_inc_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(skip_o));
endmodule

bind skip_eval skip_eval_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ir_i        (ir_i),
  .ac_i        (ac_i),
  .link_i      (link_i),
  .fetch_i     (fetch_i),
  .exec_i      (exec_i),
  .fetch_inc_o (fetch_inc_o),
  .exec_inc_o  (exec_inc_o),
  .skip_o      (skip_o)
);

// File: tb/test_skip_eval.sv
module test_skip_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] ir_i = '0;
  logic [11:0] ac_i = '0;
  logic        link_i = 1'b0;
  logic        fetch_i = 1'b0;
  logic        exec_i = 1'b0;
  logic        fetch_inc_o, exec_inc_o, skip_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  skip_eval i_skip_eval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ir_i        (ir_i),
    .ac_i        (ac_i),
    .link_i      (link_i),
    .fetch_i     (fetch_i),
    .exec_i      (exec_i),
    .fetch_inc_o (fetch_inc_o),
    .exec_inc_o  (exec_inc_o),
    .skip_o      (skip_o)
  );

  // {ir, ac, link, expected skip}
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {12'o7500, 12'o4000, 1'b0, 1'b1},  // R4 minus
    {12'o7500, 12'o3777, 1'b0, 1'b0},  // R4
    {12'o7440, 12'o0000, 1'b1, 1'b1},  // R4 zero
    {12'o7440, 12'o0001, 1'b0, 1'b0},  // R4
    {12'o7510, 12'o7777, 1'b0, 1'b0},  // R5 plus
    {12'o7510, 12'o0000, 1'b1, 1'b1},  // R5
    {12'o7450, 12'o0000, 1'b0, 1'b0},  // R5 nonzero
    {12'o7450, 12'o4000, 1'b1, 1'b1},  // R5
    {12'o7540, 12'o0000, 1'b0, 1'b1},  // R7
    {12'o7540, 12'o7777, 1'b0, 1'b1},  // R7
    {12'o7540, 12'o4000, 1'b0, 1'b1},  // R7
    {12'o7540, 12'o0001, 1'b0, 1'b0},  // R7
    {12'o7540, 12'o3777, 1'b0, 1'b0},  // R7
    {12'o7550, 12'o3777, 1'b0, 1'b1},  // R7
    {12'o7550, 12'o0001, 1'b0, 1'b1},  // R7
    {12'o7550, 12'o0000, 1'b0, 1'b0},  // R7
    {12'o7550, 12'o4000, 1'b0, 1'b0},  // R7
    {12'o7420, 12'o0000, 1'b1, 1'b1},  // R4 link
    {12'o7420, 12'o0000, 1'b0, 1'b0},  // R4
    {12'o7430, 12'o0000, 1'b0, 1'b1},  // R5 link clear
    {12'o7430, 12'o0000, 1'b1, 1'b0},  // R5
    {12'o7400, 12'o4000, 1'b1, 1'b0},  // R6 never
    {12'o7410, 12'o0000, 1'b1, 1'b1},  // R6 always
    {12'o7460, 12'o0001, 1'b1, 1'b1},  // R4 zero|link
    {12'o7460, 12'o0001, 1'b0, 1'b0},  // R4
    {12'o7470, 12'o0001, 1'b0, 1'b1},  // R5 nonzero&linkclear
    {12'o7470, 12'o0001, 1'b1, 1'b0},  // R5
    {12'o7040, 12'o0000, 1'b0, 1'b0},  // R3 group-1
    {12'o7441, 12'o0000, 1'b0, 1'b0},  // R3 bit 11 set
    {12'o3440, 12'o0000, 1'b0, 1'b0}   // R3 memory ref
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (ir=%o ac=%o l=%b)", req, act, exp, ir_i, ac_i, link_i);
    end
  endtask

  task automatic run_exec(input logic [11:0] ir, input logic [11:0] ac, input logic l,
                          input logic exp);
    @(negedge clk_i);
    ir_i = ir; ac_i = ac; link_i = l; exec_i = 1'b1;
    @(negedge clk_i);
    exec_i = 1'b0;
    check("R8 exec_inc", exec_inc_o, exp);
    check("R9 skip flag", skip_o, exp);
    check("R2 no fetch step", fetch_inc_o, 1'b0);
  endtask

  initial begin
    #1;
    check("R1 reset fetch_inc", fetch_inc_o, 1'b0);
    check("R1 reset exec_inc", exec_inc_o, 1'b0);
    check("R1 reset skip", skip_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", exec_inc_o | fetch_inc_o | skip_o, 1'b0);

    for (int i = 0; i < NV; i++)
      run_exec(VEC[i][25:14], VEC[i][13:2], VEC[i][1], VEC[i][0]);

    // R6 across all accumulator sign/zero and link combos
    for (int k = 0; k < 4; k++) begin
      run_exec(12'o7400, k[0] ? 12'o4000 : 12'o0000, k[1], 1'b0);
      run_exec(12'o7410, k[0] ? 12'o7777 : 12'o0000, k[1], 1'b1);
    end

    // R9: hold with no execute strobe; R8: single-cycle enable
    run_exec(12'o7500, 12'o4000, 1'b0, 1'b1);
    @(negedge clk_i);
    ir_i = 12'o7000; ac_i = 12'o0001; link_i = 1'b1;
    check("R8 enable one cycle", exec_inc_o, 1'b0);
    @(negedge clk_i);
    check("R9 hold flag", skip_o, 1'b1);
    check("R8 idle", exec_inc_o, 1'b0);

    // R2: fetch step regardless of instruction
    ir_i = 12'o7400; fetch_i = 1'b1;
    @(negedge clk_i);
    ir_i = 12'o3440; ac_i = 12'o7777;
    check("R2 fetch step", fetch_inc_o, 1'b1);
    check("R2 no exec step", exec_inc_o, 1'b0);
    @(negedge clk_i);
    fetch_i = 1'b0;
    check("R2 fetch step non-opr", fetch_inc_o, 1'b1);
    @(negedge clk_i);
    check("R2 fetch idle", fetch_inc_o, 1'b0);
    check("R9 flag through fetch", skip_o, 1'b1);

    // R3: non-group-2 clears flag
    run_exec(12'o7040, 12'o0000, 1'b0, 1'b0);

    // R1: reset mid-run
    run_exec(12'o7410, 12'o0000, 1'b0, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset skip", skip_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset exec_inc", exec_inc_o, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule